// File: doc/BRIEF.md
# Mouse Movement Report Decoder

This block listens to the two-wire serial link from a pointing device and turns its movement reports into parallel fields. Each report is three serial frames. The block receives the frames, checks them, and puts them together. The first frame carries the button and sign/overflow flags. The second carries the horizontal magnitude. The third carries the vertical magnitude.

For every complete and error-free report, the block updates its outputs and raises a one-cycle strobe. The outputs are:
- the left and right button states,
- two 9-bit two's-complement movement values,
- two overflow flags.

The outputs then hold their values until the next good report. The block only listens; it never drives the link.

The block recovers from faults in three ways:
- A first frame that fails the alignment check is dropped.
- A frame that fails its integrity checks discards the report being built.
- A long silence on the link discards a partly received frame or report.

The silence limit is a parameter in microseconds. It is converted to system clock cycles from the clock-frequency parameter.

Top module: `mouse_report_decoder`

## Requirements
- R1: While `rst_n` is low, and after it is released before any report, `pkt_valid`, `btn_left`, `btn_right`, `ovf_x` and `ovf_y` are 0, and `move_x` and `move_y` are 0.
- R2: A frame is sampled on falling edges of `ps2_clk`, after both lines are synchronised to `clk`. A frame is a 0 start bit, then 8 data bits with the least significant bit first, then a parity bit that makes the count of ones across data and parity odd, then a 1 stop bit.
- R3: Three good frames in the order flags, horizontal, vertical produce exactly one `pkt_valid` pulse, one `clk` cycle wide.
- R4: `btn_left` equals bit 0 and `btn_right` equals bit 1 of the flags byte of the latest good report.
- R5: `move_x` equals {flags bit 4, horizontal byte} and `move_y` equals {flags bit 5, vertical byte}, both as 9-bit two's complement. A positive value means right or up.
- R6: `ovf_x` equals flags bit 6 and `ovf_y` equals flags bit 7.
- R7: A frame expected to be the flags byte is dropped when its bit 3 is 0. The next frame is then treated as a flags byte.
- R8: A frame with wrong parity or a 0 stop bit discards the report in progress. The next frame is treated as a flags byte.
- R9: When no `ps2_clk` falling edge is seen for GAP_US microseconds, any partial frame and partial report are discarded.
- R10: Between `pkt_valid` pulses, all report outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ps2_clk | input | 1 | Serial link clock from the device, idle high |
| ps2_data | input | 1 | Serial link data from the device, idle high |
| pkt_valid | output | 1 | One-cycle strobe when a new report is presented |
| btn_left | output | 1 | Left button pressed |
| btn_right | output | 1 | Right button pressed |
| move_x | output | 9 | Signed horizontal movement |
| move_y | output | 9 | Signed vertical movement |
| ovf_x | output | 1 | Horizontal movement overflow |
| ovf_y | output | 1 | Vertical movement overflow |

## Verification
The assertions check several properties on every cycle:
- the strobe is one cycle wide,
- the strobe only follows a good frame,
- the frame bit counter stays in range,
- a completed frame always follows a link clock fall,
- the silence pulse is a single cycle,
- a flags byte with bit 3 clear leaves the assembler waiting for a flags byte,
- the report outputs stay stable when there is no strobe.

Only the bench scenarios can show that the decoded fields match the serial bytes. The same holds for dropping a misaligned flags byte, discarding a report on a bad parity or stop bit, and discarding a report after a silence, followed by a clean report.

// File: rtl/mrd_pkg.sv
// Shared types and constants for the mouse report decoder.
// Assumes a report is three bytes: flags, horizontal, vertical.
package mrd_pkg;

    localparam int BYTE_W      = 8;
    localparam int FRAME_BITS  = 11;
    localparam int MOVE_W      = BYTE_W + 1;

    // flags byte bit positions (decoded below, so kept fixed)
    localparam int F_LEFT  = 0;
    localparam int F_RIGHT = 1;
    localparam int F_SYNC  = 3;
    localparam int F_XSIGN = 4;
    localparam int F_YSIGN = 5;
    localparam int F_XOVF  = 6;
    localparam int F_YOVF  = 7;

    typedef enum logic [1:0] {
        ASM_FLAGS = 2'd0,
        ASM_HORZ  = 2'd1,
        ASM_VERT  = 2'd2
    } asm_state_t;

    typedef struct packed {
        logic              left;
        logic              right;
        logic [MOVE_W-1:0] dx;
        logic [MOVE_W-1:0] dy;
        logic              ovfx;
        logic              ovfy;
    } mouse_report_t;

endpackage

// File: rtl/mrd_line_sync.sv
// Brings the two link lines into the clk domain and flags link clock falls.
// Assumes both lines idle high; the chain resets to 1 so no false fall occurs.
module mrd_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lnk_clk_raw,
    input  logic lnk_dat_raw,
    output logic lnk_fall,
    output logic lnk_dat
);

    logic [1:0] chain [STAGES];
    logic       clk_prev;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // one synchroniser flop per stage for both lines
            always_ff @(posedge clk) begin
                if (!rst_n)
                    chain[g] <= 2'b11;
                else if (g == 0)
                    chain[g] <= {lnk_clk_raw, lnk_dat_raw};
                else
                    chain[g] <= chain[(g > 0) ? g-1 : 0];
            end
        end
    endgenerate

    // remember the previous synchronised clock level
    always_ff @(posedge clk) begin
        if (!rst_n)
            clk_prev <= 1'b1;
        else
            clk_prev <= chain[STAGES-1][1];
    end

    assign lnk_fall = clk_prev & ~chain[STAGES-1][1];
    assign lnk_dat  = chain[STAGES-1][0];

endmodule

// File: rtl/mrd_gap_timer.sv
// Counts clk cycles since the last link clock fall; pulses once at the limit.
// Assumes GAP_CYCLES >= 2.
module mrd_gap_timer #(
    parameter int GAP_CYCLES = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lnk_fall,
    output logic stale
);

    localparam int CNT_W = $clog2(GAP_CYCLES + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(GAP_CYCLES);

    logic [CNT_W-1:0] idle_cnt;

    // saturating idle counter, cleared by each fall
    always_ff @(posedge clk) begin
        if (!rst_n)
            idle_cnt <= '0;
        else if (lnk_fall)
            idle_cnt <= '0;
        else if (idle_cnt != LIMIT)
            idle_cnt <= idle_cnt + 1'b1;
    end

    // single pulse when the count reaches the limit
    always_ff @(posedge clk) begin
        if (!rst_n)
            stale <= 1'b0;
        else
            stale <= !lnk_fall && (idle_cnt == LIMIT - 1'b1);
    end

    // R9
    stale_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stale |=> !stale);

endmodule

// File: rtl/mrd_frame_rx.sv
// Receives one 11-bit frame per call: start, 8 data LSB first, odd parity, stop.
// Assumes lnk_fall marks a sample point with lnk_dat stable; abort clears it.
module mrd_frame_rx
    import mrd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lnk_fall,
    input  logic              lnk_dat,
    input  logic              abort,
    output logic              frame_vld,
    output logic              frame_ok,
    output logic [BYTE_W-1:0] frame_byte
);

    localparam int IDX_W = $clog2(FRAME_BITS + 1);
    localparam logic [IDX_W-1:0] IDX_PAR  = IDX_W'(BYTE_W + 1);
    localparam logic [IDX_W-1:0] IDX_STOP = IDX_W'(BYTE_W + 2);

    logic [IDX_W-1:0]  bit_idx;
    logic [BYTE_W-1:0] shreg;
    logic              par_bit;

    // bit sequencer, shift register and frame completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_idx    <= '0;
            shreg      <= '0;
            par_bit    <= 1'b0;
            frame_vld  <= 1'b0;
            frame_ok   <= 1'b0;
            frame_byte <= '0;
        end else begin
            frame_vld <= 1'b0;
            if (abort) begin
                bit_idx <= '0;
            end else if (lnk_fall) begin
                if (bit_idx == '0) begin
                    if (!lnk_dat)
                        bit_idx <= 1'b1;
                end else if (bit_idx == IDX_PAR) begin
                    par_bit <= lnk_dat;
                    bit_idx <= bit_idx + 1'b1;
                end else if (bit_idx == IDX_STOP) begin
                    frame_vld  <= 1'b1;
                    frame_byte <= shreg;
                    frame_ok   <= lnk_dat & (^shreg ^ par_bit);
                    bit_idx    <= '0;
                end else begin
                    shreg   <= {lnk_dat, shreg[BYTE_W-1:1]};
                    bit_idx <= bit_idx + 1'b1;
                end
            end
        end
    end

    // R2
    frame_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_vld |-> $past(lnk_fall));

    // R2
    bit_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_idx <= IDX_STOP);

endmodule

// File: rtl/mrd_packet_asm.sv
// Puts three checked frames together into one report and presents it.
// Assumes frame_vld pulses one cycle per frame; stale drops partial reports.
module mrd_packet_asm
    import mrd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_vld,
    input  logic              frame_ok,
    input  logic [BYTE_W-1:0] frame_byte,
    input  logic              stale,
    output mouse_report_t     report,
    output logic              pkt_valid
);

    asm_state_t        state;
    logic [BYTE_W-1:0] flags_q;
    logic [BYTE_W-1:0] horz_q;

    // report sequencing, alignment and error recovery
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ASM_FLAGS;
            flags_q   <= '0;
            horz_q    <= '0;
            report    <= '0;
            pkt_valid <= 1'b0;
        end else begin
            pkt_valid <= 1'b0;
            if (stale) begin
                state <= ASM_FLAGS;
            end else if (frame_vld) begin
                if (!frame_ok) begin
                    state <= ASM_FLAGS;
                end else begin
                    unique case (state)
                        ASM_FLAGS: begin
                            if (frame_byte[F_SYNC]) begin
                                flags_q <= frame_byte;
                                state   <= ASM_HORZ;
                            end
                        end
                        ASM_HORZ: begin
                            horz_q <= frame_byte;
                            state  <= ASM_VERT;
                        end
                        ASM_VERT: begin
                            report.left  <= flags_q[F_LEFT];
                            report.right <= flags_q[F_RIGHT];
                            report.dx    <= {flags_q[F_XSIGN], horz_q};
                            report.dy    <= {flags_q[F_YSIGN], frame_byte};
                            report.ovfx  <= flags_q[F_XOVF];
                            report.ovfy  <= flags_q[F_YOVF];
                            pkt_valid    <= 1'b1;
                            state        <= ASM_FLAGS;
                        end
                        default: state <= ASM_FLAGS;
                    endcase
                end
            end
        end
    end

    // R3
    strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |=> !pkt_valid);

    // R3
    strobe_after_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> $past(frame_vld && frame_ok));

    // R7
    misalign_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_vld && frame_ok && !stale && state == ASM_FLAGS && !frame_byte[F_SYNC])
        |=> state == ASM_FLAGS);

    // R10
    report_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pkt_valid |-> $stable(report));

endmodule

// File: rtl/mouse_report_decoder.sv
// Top: decodes three-frame movement reports from a listen-only serial link.
// Assumes CLK_HZ is a multiple of 1 MHz; GAP_US sets the silence limit.
module mouse_report_decoder #(
    parameter int CLK_HZ      = 50_000_000,
    parameter int GAP_US      = 2000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ps2_clk,
    input  logic       ps2_data,
    output logic       pkt_valid,
    output logic       btn_left,
    output logic       btn_right,
    output logic [8:0] move_x,
    output logic [8:0] move_y,
    output logic       ovf_x,
    output logic       ovf_y
);

    import mrd_pkg::*;

    localparam int GAP_CYCLES = (CLK_HZ / 1_000_000) * GAP_US;

    logic              lnk_fall;
    logic              lnk_dat;
    logic              stale;
    logic              frame_vld;
    logic              frame_ok;
    logic [BYTE_W-1:0] frame_byte;
    mouse_report_t     report;

    mrd_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .lnk_clk_raw(ps2_clk), .lnk_dat_raw(ps2_data),
        .lnk_fall(lnk_fall), .lnk_dat(lnk_dat)
    );

    mrd_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
        .clk(clk), .rst_n(rst_n), .lnk_fall(lnk_fall), .stale(stale)
    );

    mrd_frame_rx u_rx (
        .clk(clk), .rst_n(rst_n),
        .lnk_fall(lnk_fall), .lnk_dat(lnk_dat), .abort(stale),
        .frame_vld(frame_vld), .frame_ok(frame_ok), .frame_byte(frame_byte)
    );

    mrd_packet_asm u_asm (
        .clk(clk), .rst_n(rst_n),
        .frame_vld(frame_vld), .frame_ok(frame_ok), .frame_byte(frame_byte),
        .stale(stale), .report(report), .pkt_valid(pkt_valid)
    );

    assign btn_left  = report.left;
    assign btn_right = report.right;
    assign move_x    = report.dx;
    assign move_y    = report.dy;
    assign ovf_x     = report.ovfx;
    assign ovf_y     = report.ovfy;

endmodule

// File: tb/tb_mouse_report_decoder.sv
module tb_mouse_report_decoder;

    localparam int HALF = 10;   // link clock half period in clk cycles

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ps2_clk = 1'b1;
    logic       ps2_data = 1'b1;
    logic       pkt_valid, btn_left, btn_right, ovf_x, ovf_y;
    logic [8:0] move_x, move_y;

    int n_cmp = 0;
    int n_bad = 0;
    int n_valid = 0;
    logic prev_v = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    mouse_report_decoder #(.CLK_HZ(50_000_000), .GAP_US(8)) dut (
        .clk(clk), .rst_n(rst_n), .ps2_clk(ps2_clk), .ps2_data(ps2_data),
        .pkt_valid(pkt_valid), .btn_left(btn_left), .btn_right(btn_right),
        .move_x(move_x), .move_y(move_y), .ovf_x(ovf_x), .ovf_y(ovf_y)
    );

    // strobe monitor: count pulses and check the one-cycle width (R3)
    always @(negedge clk) begin
        if (rst_n) begin
            if (pkt_valid) n_valid++;
            if (pkt_valid && prev_v) begin
                n_bad++;
                $display("FAIL R3 strobe wider than one cycle: actual 2 expected 1");
            end
            prev_v <= pkt_valid;
        end
    end

    function automatic logic [8:0] exp_dx(logic [7:0] f, logic [7:0] x);
        return {f[4], x};
    endfunction
    function automatic logic [8:0] exp_dy(logic [7:0] f, logic [7:0] y);
        return {f[5], y};
    endfunction

    task automatic chk(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(logic b);
        ps2_data = b;
        wait_clk(HALF);
        ps2_clk = 1'b0;
        wait_clk(HALF);
        ps2_clk = 1'b1;
    endtask

    // one frame; bad_par flips parity, bad_stop sends a 0 stop bit (R2)
    task automatic send_frame(logic [7:0] b, bit bad_par, bit bad_stop);
        send_bit(1'b0);
        for (int i = 0; i < 8; i++) send_bit(b[i]);
        send_bit(~(^b) ^ bad_par);
        send_bit(~bad_stop);
        ps2_data = 1'b1;
        wait_clk(4 * HALF);
    endtask

    task automatic send_pkt(logic [7:0] f, logic [7:0] x, logic [7:0] y);
        send_frame(f, 0, 0);
        send_frame(x, 0, 0);
        send_frame(y, 0, 0);
    endtask

    // compare all outputs with the expected report, and the pulse count
    task automatic chk_report(string tag, int v0, int nv,
                              logic [7:0] f, logic [7:0] x, logic [7:0] y);
        chk({tag, " R3 pulse count"}, n_valid - v0, nv);
        chk({tag, " R4 left"},  int'(btn_left),  int'(f[0]));
        chk({tag, " R4 right"}, int'(btn_right), int'(f[1]));
        chk({tag, " R5 move_x"}, int'(move_x), int'(exp_dx(f, x)));
        chk({tag, " R5 move_y"}, int'(move_y), int'(exp_dy(f, y)));
        chk({tag, " R6 ovf_x"}, int'(ovf_x), int'(f[6]));
        chk({tag, " R6 ovf_y"}, int'(ovf_y), int'(f[7]));
    endtask

    initial begin
        logic [7:0] f, x, y, f2, x2, y2;
        int v0;
        void'($urandom(32'd20240611));
        wait_clk(5);
        // R1: reset values while reset is held
        chk("R1 valid in reset", int'(pkt_valid), 0);
        chk("R1 fields in reset",
            int'({btn_left, btn_right, move_x, move_y, ovf_x, ovf_y}), 0);
        rst_n = 1'b1;
        wait_clk(5);
        chk("R1 fields after release",
            int'({pkt_valid, btn_left, btn_right, move_x, move_y, ovf_x, ovf_y}), 0);

        // directed corners: all set, all minimal (R5 sign extremes)
        v0 = n_valid; send_pkt(8'hFB, 8'h80, 8'hFF); chk_report("dir1", v0, 1, 8'hFB, 8'h80, 8'hFF);
        v0 = n_valid; send_pkt(8'h08, 8'h00, 8'h7F); chk_report("dir2", v0, 1, 8'h08, 8'h00, 8'h7F);

        // random reports, R2 bit order exercised via field checks
        for (int k = 0; k < 8; k++) begin
            f = 8'($urandom) | 8'h08; x = 8'($urandom); y = 8'($urandom);
            v0 = n_valid; send_pkt(f, x, y); chk_report("rand", v0, 1, f, x, y);
        end

        // R7 and R10: misaligned flags byte dropped, outputs hold
        f = 8'h39; x = 8'h12; y = 8'h34;
        v0 = n_valid; send_pkt(f, x, y);
        send_frame(8'h37, 0, 0);   // bit 3 clear: dropped
        wait_clk(40);
        chk_report("R7/R10 hold", v0, 1, f, x, y);
        f2 = 8'hC9; x2 = 8'h55; y2 = 8'hAA;
        v0 = n_valid; send_pkt(f2, x2, y2);
        chk_report("R7 realign", v0, 1, f2, x2, y2);

        // R8: parity error in horizontal frame discards the report
        v0 = n_valid;
        send_frame(8'h2A, 0, 0); send_frame(8'h11, 1, 0);
        f = 8'h1E; x = 8'h44; y = 8'h66;
        send_pkt(f, x, y);
        chk_report("R8 parity", v0, 1, f, x, y);

        // R8: bad stop bit in vertical frame discards the report
        v0 = n_valid;
        send_frame(8'h0C, 0, 0); send_frame(8'h01, 0, 0); send_frame(8'h02, 0, 1);
        chk("R8 stop no strobe", n_valid - v0, 0);
        f = 8'h2D; x = 8'h9C; y = 8'h03;
        send_pkt(f, x, y);
        chk_report("R8 stop", v0, 1, f, x, y);

        // R9: silence after two frames discards the partial report
        v0 = n_valid;
        send_frame(8'h0B, 0, 0); send_frame(8'h77, 0, 0);
        wait_clk(700);
        f = 8'h18; x = 8'hE0; y = 8'h21;
        send_pkt(f, x, y);
        chk_report("R9 gap", v0, 1, f, x, y);

        // R9: silence in the middle of a frame drops that frame
        v0 = n_valid;
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        wait_clk(700);
        f = 8'h0A; x = 8'h05; y = 8'hF6;
        send_pkt(f, x, y);
        chk_report("R9 midframe", v0, 1, f, x, y);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule